// File: doc/BRIEF.md
# Counter and Timer Register Frame

This block puts a free-running 64-bit system count and two compare-timer channels behind a simple request/response register port. Channel 0 compares against the raw count. Channel 1 compares against a virtual count, which is the raw count minus a programmable offset. There are two address frames, selected by `req_ctrl`. The timer frame shows the counts, a read-only mirror of the frequency value, and the compare, timer-value and control words of each channel. The control frame holds the frequency (writable once), the virtual offset, two plain 32-bit access words and a read-only identifier.

A controller with three states handles each request:

- `ST_IDLE` accepts a request while `req_ready` is high.
- Accepting a legal request is the transition `IDLE->REPLY`. All register effects happen on that accept edge.
- Accepting a request with an illegal size is the transition `IDLE->FAULT`, and the response carries `rsp_err`.
- Both `ST_REPLY` and `ST_FAULT` leave through `REPLY/FAULT->IDLE` after exactly one cycle.

Any 64-bit quantity can be reached as two 32-bit words, at the low word and at the low word + 4. It can also be reached as one 64-bit access at its low-word address. Unmapped, misaligned or wrongly sized offsets read as zero and ignore writes.

Top module: `cntr_regframe`

## Requirements
- R1: `req_size` encodes the access size: 2'b10 is 4 bytes and 2'b11 is 8 bytes. Codes 2'b00 and 2'b01 (1 and 2 bytes) produce a response with `rsp_err`=1 and zero data, and they change no register.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high in exactly the following cycle. `req_ready` is low in that cycle.
- R3: The count increments by one every clock after reset and reads as 0 at reset. In the timer frame it sits at 0x00 (low word) and 0x04 (high word). A 64-bit access at 0x00 returns all 64 bits. Each read returns the count held just before the accept edge.
- R4: The virtual count, at timer-frame 0x08 and 0x0C, equals the count minus the offset, modulo 2^64. The offset sits at control-frame 0x18 and 0x1C and resets to 0.
- R5: Writes to the count addresses 0x00 to 0x0C are ignored.
- R6: Frequency resets to 0. The first write to control-frame 0x00 stores bits 31:0, and every later write is ignored. Timer-frame 0x10 reads the same value and ignores writes.
- R7: Each channel has a 64-bit compare word: channel 0 at timer-frame 0x20/0x24, channel 1 at 0x30/0x34. A 32-bit write to the low word changes only bits 31:0. A 32-bit write to the high word changes only bits 63:32. A 64-bit write at the low word sets the whole word.
- R8: The timer-value word (0x28 for channel 0, 0x38 for channel 1) reads as bits 31:0 of the compare word minus the channel's count. Writing it sets the compare word to the channel's count plus the sign-extended 32-bit value.
- R9: The channel control word (0x2C for channel 0, 0x3C for channel 1) has bit 0 enable and bit 1 mask, both read/write. Bit 2 is a read-only status: enable AND (channel count >= compare word). Channel 1 uses the virtual count.
- R10: Control-frame 0x04 and 0x10 are 32-bit read/write words that reset to 0. Control-frame 0x08 reads the constant `TIMER_ID` and ignores writes.
- R11: Every other offset reads as zero and ignores writes, with no error. This includes offsets not 4-byte aligned, offsets of 0x40 and above, 64-bit accesses to any address that is not the low word of a 64-bit pair, and 64-bit accesses at the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctrl | input | 1 | 1 = control frame, 0 = timer frame |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data, low-aligned for 32-bit accesses |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Illegal access size |
| rsp_rdata | output | 64 | Read data, zero for writes and faults |

## Verification
The count paths are tried with back-to-back reads and with reads placed around ignored writes. The count difference separates a correct read-only path from one that a write can disturb. A large offset that wraps the virtual count makes its high word nonzero, which tells a high-word read apart from a low-word read. Pair writes mixing 64-bit, low-only and high-only accesses show whether half-select is correct. Equal compare values on both channels, with only the virtual count past the compare, show whether each channel's status uses its own count. A full sweep of every unmapped offset, in both frames and at both sizes, checks read-as-zero and checks that no stray write reached a stored register.

// File: rtl/cntr_regframe_pkg.sv
package cntr_regframe_pkg;
    localparam int REG_W  = 64;
    localparam int WORD_W = REG_W / 2;
    localparam int N_CHAN = 2;
    localparam int FRAME_BITS = 6;

    localparam logic [1:0] SZ_WORD  = 2'b10;
    localparam logic [1:0] SZ_DWORD = 2'b11;

    typedef enum logic [1:0] {ST_IDLE, ST_REPLY, ST_FAULT} fsm_e;

    typedef enum logic [3:0] {
        RID_NONE, RID_PCNT, RID_VCNT, RID_TFREQ, RID_CVAL, RID_TVAL, RID_CTL,
        RID_CFREQ, RID_NSACC, RID_TID, RID_ACR, RID_VOFF
    } rid_e;

    typedef struct packed {
        rid_e rid;
        logic chan;
        logic hi;
        logic wide;
    } dec_t;
endpackage

// File: rtl/cntr_sys_counter.sv
module cntr_sys_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/cntr_addr_decode.sv
module cntr_addr_decode
    import cntr_regframe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output dec_t              dec
);
    localparam int WIDX_W = FRAME_BITS - 2;

    logic [WIDX_W-1:0] widx;
    logic              in_frame;
    logic              pair_lo;

    assign widx     = addr[FRAME_BITS-1:2];
    assign in_frame = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:FRAME_BITS] == '0);

    always_comb begin
        dec.rid  = RID_NONE;
        dec.chan = 1'b0;
        dec.hi   = 1'b0;
        dec.wide = wide;
        pair_lo  = 1'b0;
        if (in_frame) begin
            if (!ctrl) begin
                if (widx[3]) begin
                    dec.chan = widx[2];
                    unique case (widx[1:0])
                        2'd0: begin dec.rid = RID_CVAL; pair_lo = 1'b1; end
                        2'd1: begin dec.rid = RID_CVAL; dec.hi = 1'b1; end
                        2'd2: dec.rid = RID_TVAL;
                        2'd3: dec.rid = RID_CTL;
                        default: dec.rid = RID_NONE;
                    endcase
                end else begin
                    unique case (widx[2:0])
                        3'd0: begin dec.rid = RID_PCNT; pair_lo = 1'b1; end
                        3'd1: begin dec.rid = RID_PCNT; dec.hi = 1'b1; end
                        3'd2: begin dec.rid = RID_VCNT; pair_lo = 1'b1; end
                        3'd3: begin dec.rid = RID_VCNT; dec.hi = 1'b1; end
                        3'd4: dec.rid = RID_TFREQ;
                        default: dec.rid = RID_NONE;
                    endcase
                end
            end else begin
                unique case (widx)
                    4'd0: dec.rid = RID_CFREQ;
                    4'd1: dec.rid = RID_NSACC;
                    4'd2: dec.rid = RID_TID;
                    4'd4: dec.rid = RID_ACR;
                    4'd6: begin dec.rid = RID_VOFF; pair_lo = 1'b1; end
                    4'd7: begin dec.rid = RID_VOFF; dec.hi = 1'b1; end
                    default: dec.rid = RID_NONE;
                endcase
            end
        end
        if (wide && !pair_lo) begin
            dec.rid  = RID_NONE;
            dec.hi   = 1'b0;
            dec.chan = 1'b0;
        end
    end
endmodule

// File: rtl/cntr_timer_chan.sv
module cntr_timer_chan #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cval_we_lo,
    input  logic             cval_we_hi,
    input  logic             tval_we,
    input  logic             ctl_we,
    output logic [CNT_W-1:0] cval,
    output logic [2:0]       ctl
);
    localparam int HALF = CNT_W / 2;

    logic en_q;
    logic mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cval   <= '0;
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (tval_we) begin
                cval <= now + {{HALF{wdata[HALF-1]}}, wdata[HALF-1:0]};
            end else begin
                if (cval_we_lo) cval[HALF-1:0]     <= wdata[HALF-1:0];
                if (cval_we_hi) cval[CNT_W-1:HALF] <= wdata[CNT_W-1:HALF];
            end
            if (ctl_we) begin
                en_q   <= wdata[0];
                mask_q <= wdata[1];
            end
        end
    end

    assign ctl = {en_q && (now >= cval), mask_q, en_q};
endmodule

// File: rtl/cntr_regframe.sv
module cntr_regframe
    import cntr_regframe_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] TIMER_ID = 32'h0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_ctrl,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [REG_W-1:0]  rsp_rdata
);
    fsm_e               state_q;
    dec_t               dec;
    logic               accept;
    logic               legal;
    logic               wr;
    logic               we_lo;
    logic               we_hi;
    logic [REG_W-1:0]   wal;
    logic [REG_W-1:0]   cnt_now;
    logic [REG_W-1:0]   vcnt;
    logic [REG_W-1:0]   voff_q;
    logic [WORD_W-1:0]  freq_q;
    logic               freq_set_q;
    logic [WORD_W-1:0]  nsacc_q;
    logic [WORD_W-1:0]  acr_q;
    logic [REG_W-1:0]   full;
    logic [REG_W-1:0]   rd_val;
    logic [REG_W-1:0]   rdata_q;
    logic [REG_W-1:0]   chan_now  [N_CHAN];
    logic [REG_W-1:0]   chan_cval [N_CHAN];
    logic [2:0]         chan_ctl  [N_CHAN];
    logic [REG_W-1:0]   sel_diff;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign legal  = (req_size == SZ_WORD) || (req_size == SZ_DWORD);
    assign wr     = accept && legal && req_write;
    assign we_lo  = dec.wide || !dec.hi;
    assign we_hi  = dec.wide || dec.hi;
    assign wal    = dec.wide ? req_wdata
                  : (dec.hi ? {req_wdata[WORD_W-1:0], {WORD_W{1'b0}}}
                            : {{WORD_W{1'b0}}, req_wdata[WORD_W-1:0]});
    assign vcnt   = cnt_now - voff_q;

    cntr_sys_counter #(.CNT_W(REG_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_now)
    );

    cntr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ctrl (req_ctrl),
        .addr (req_addr),
        .wide (req_size == SZ_DWORD),
        .dec  (dec)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        logic hit;
        assign hit         = wr && (dec.chan == g[0]);
        assign chan_now[g] = (g == 0) ? cnt_now : vcnt;
        cntr_timer_chan #(.CNT_W(REG_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .now        (chan_now[g]),
            .wdata      (wal),
            .cval_we_lo (hit && dec.rid == RID_CVAL && we_lo),
            .cval_we_hi (hit && dec.rid == RID_CVAL && we_hi),
            .tval_we    (hit && dec.rid == RID_TVAL),
            .ctl_we     (hit && dec.rid == RID_CTL),
            .cval       (chan_cval[g]),
            .ctl        (chan_ctl[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q     <= '0;
            freq_set_q <= 1'b0;
            nsacc_q    <= '0;
            acr_q      <= '0;
            voff_q     <= '0;
        end else if (wr) begin
            unique case (dec.rid)
                RID_CFREQ: if (!freq_set_q) begin
                    freq_q     <= req_wdata[WORD_W-1:0];
                    freq_set_q <= 1'b1;
                end
                RID_NSACC: nsacc_q <= req_wdata[WORD_W-1:0];
                RID_ACR:   acr_q   <= req_wdata[WORD_W-1:0];
                RID_VOFF: begin
                    if (we_lo) voff_q[WORD_W-1:0]     <= wal[WORD_W-1:0];
                    if (we_hi) voff_q[REG_W-1:WORD_W] <= wal[REG_W-1:WORD_W];
                end
                default: ;
            endcase
        end
    end

    assign sel_diff = chan_cval[dec.chan] - chan_now[dec.chan];

    always_comb begin
        full = '0;
        unique case (dec.rid)
            RID_PCNT:             full = cnt_now;
            RID_VCNT:             full = vcnt;
            RID_TFREQ, RID_CFREQ: full = {{WORD_W{1'b0}}, freq_q};
            RID_CVAL:             full = chan_cval[dec.chan];
            RID_TVAL:             full = {{WORD_W{1'b0}}, sel_diff[WORD_W-1:0]};
            RID_CTL:              full = {{(REG_W-3){1'b0}}, chan_ctl[dec.chan]};
            RID_NSACC:            full = {{WORD_W{1'b0}}, nsacc_q};
            RID_TID:              full = {{WORD_W{1'b0}}, TIMER_ID};
            RID_ACR:              full = {{WORD_W{1'b0}}, acr_q};
            RID_VOFF:             full = voff_q;
            default:              full = '0;
        endcase
        rd_val = dec.wide ? full
               : {{WORD_W{1'b0}}, (dec.hi ? full[REG_W-1:WORD_W] : full[WORD_W-1:0])};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= legal ? ST_REPLY : ST_FAULT;
                    rdata_q <= (legal && !req_write) ? rd_val : '0;
                end
                ST_REPLY, ST_FAULT: state_q <= ST_IDLE;
                default:            state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q != ST_IDLE);
        rsp_err   = (state_q == ST_FAULT);
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/cntr_regframe_chk.sv
module cntr_regframe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic [63:0] cnt_now,
    input logic [31:0] freq_q,
    input logic        freq_set_q
);
    assert_fault_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'd0));

    assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_size[1]) |=> rsp_err);

    assert_reply_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_single_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cnt_now == $past(cnt_now) + 64'd1));

    assert_freq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(freq_set_q) |-> $stable(freq_q));

    assert_freq_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_set_q |=> freq_set_q);
endmodule

bind cntr_regframe cntr_regframe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .cnt_now    (cnt_now),
    .freq_q     (freq_q),
    .freq_set_q (freq_set_q)
);

// File: tb/sim_cntr_regframe.sv
module sim_cntr_regframe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_ctrl = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [31:0] EXP_ID = 32'h0000_0011;

    always #10 clk = ~clk;

    cntr_regframe u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_ctrl(req_ctrl), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    logic [63:0] last_rd;
    logic        last_err;
    logic        last_vld;

    task automatic xfer(input logic w, input logic c, input logic [7:0] a,
                        input logic [1:0] sz, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_ctrl = c;
        req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        last_rd = rsp_rdata; last_err = rsp_err; last_vld = rsp_valid;
        @(posedge clk);
    endtask

    task automatic rd(input logic c, input logic [7:0] a, input logic [1:0] sz,
                      output logic [63:0] v);
        xfer(1'b0, c, a, sz, 64'd0);
        v = last_rd;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit mapped(int c, int a, int w);
        int wi;
        if (a >= 64 || (a % 4) != 0) return 0;
        wi = a / 4;
        if (c == 0) begin
            if (w != 0) return (wi == 0 || wi == 2 || wi == 8 || wi == 12);
            return (wi <= 4) || (wi >= 8 && wi <= 15);
        end
        if (w != 0) return (wi == 6);
        return (wi == 0 || wi == 1 || wi == 2 || wi == 4 || wi == 6 || wi == 7);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, c, p, t, h, voff;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R2 ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R2 no response after reset", {63'd0, rsp_valid}, 64'd0);

        // R6 frequency write-once
        rd(1, 8'h00, 2'b10, a); chk("R6 freq reset", a, 64'd0);
        xfer(1, 1, 8'h00, 2'b10, 64'd1000);
        chk("R2 response valid", {63'd0, last_vld}, 64'd1);
        rd(0, 8'h10, 2'b10, a); chk("R6 timer-frame mirror", a, 64'd1000);
        xfer(1, 1, 8'h00, 2'b10, 64'd55);
        rd(1, 8'h00, 2'b10, a); chk("R6 second write ignored", a, 64'd1000);
        xfer(1, 0, 8'h10, 2'b10, 64'd77);
        rd(1, 8'h00, 2'b10, a); chk("R6 mirror read-only", a, 64'd1000);

        // R3 count
        rd(0, 8'h00, 2'b10, a); rd(0, 8'h00, 2'b11, b);
        chk("R3 count step", b - a, 64'd2);
        rd(0, 8'h04, 2'b10, a); chk("R3 count high word", a, 64'd0);

        // R5 count read-only
        rd(0, 8'h00, 2'b11, a);
        xfer(1, 0, 8'h00, 2'b11, 64'hDEAD_BEEF_0000_0000);
        rd(0, 8'h00, 2'b11, b); chk("R5 phys write ignored", b - a, 64'd4);
        xfer(1, 0, 8'h0C, 2'b10, 64'h1234);
        rd(0, 8'h00, 2'b11, a); chk("R5 virt write ignored", a - b, 64'd4);

        // R4 virtual count
        voff = 64'hFFFF_FFF0_0000_0000;
        xfer(1, 1, 8'h18, 2'b11, voff);
        rd(0, 8'h08, 2'b11, a); rd(0, 8'h00, 2'b11, p);
        chk("R4 virtual count", p - a, voff + 64'd2);
        rd(0, 8'h0C, 2'b10, h); rd(0, 8'h00, 2'b11, p);
        chk("R4 virtual high word", h, {32'd0, ((p - 64'd2) - voff) >> 32});
        xfer(1, 1, 8'h1C, 2'b10, 64'h1234_5678);
        rd(1, 8'h18, 2'b11, a); chk("R4 offset high half", a, 64'h1234_5678_0000_0000);
        rd(1, 8'h18, 2'b10, a); chk("R4 offset low word", a, 64'd0);

        // R7 compare pair
        xfer(1, 0, 8'h20, 2'b11, 64'h1111_2222_3333_4444);
        xfer(1, 0, 8'h24, 2'b10, 64'hAAAA_BBBB);
        rd(0, 8'h20, 2'b11, a); chk("R7 high half write", a, 64'hAAAA_BBBB_3333_4444);
        xfer(1, 0, 8'h20, 2'b10, 64'h55);
        rd(0, 8'h20, 2'b11, a); chk("R7 low half write", a, 64'hAAAA_BBBB_0000_0055);
        rd(0, 8'h24, 2'b10, a); chk("R7 high word read", a, 64'hAAAA_BBBB);

        // R8 timer value
        xfer(1, 0, 8'h28, 2'b10, 64'd100);
        rd(0, 8'h20, 2'b11, c); rd(0, 8'h00, 2'b11, p);
        chk("R8 positive timer value", c, p - 64'd4 + 64'd100);
        rd(0, 8'h28, 2'b10, t); rd(0, 8'h20, 2'b11, c); rd(0, 8'h00, 2'b11, p);
        chk("R8 timer value read", t, {32'd0, 32'(c - (p - 64'd4))});
        xfer(1, 0, 8'h28, 2'b10, 64'hFFFF_FFF0);
        rd(0, 8'h20, 2'b11, c); rd(0, 8'h00, 2'b11, p);
        chk("R8 negative timer value", c, p - 64'd4 - 64'd16);

        // R9 control and status
        xfer(1, 0, 8'h2C, 2'b10, 64'h7);
        rd(0, 8'h2C, 2'b10, a); chk("R9 status when passed", a, 64'h7);
        xfer(1, 0, 8'h2C, 2'b10, 64'h2);
        rd(0, 8'h2C, 2'b10, a); chk("R9 status needs enable", a, 64'h2);
        xfer(1, 1, 8'h18, 2'b11, 64'h1_0000_0000);
        xfer(1, 0, 8'h20, 2'b11, 64'h8000_0000_0000_0000);
        xfer(1, 0, 8'h30, 2'b11, 64'h8000_0000_0000_0000);
        xfer(1, 0, 8'h2C, 2'b10, 64'h1);
        xfer(1, 0, 8'h3C, 2'b10, 64'h1);
        rd(0, 8'h2C, 2'b10, a); chk("R9 phys not passed", a, 64'h1);
        rd(0, 8'h3C, 2'b10, a); chk("R9 virtual uses virtual count", a, 64'h5);

        // R10 control frame words
        xfer(1, 1, 8'h04, 2'b10, 64'hA5A5_5A5A);
        xfer(1, 1, 8'h10, 2'b10, 64'h3F);
        xfer(1, 1, 8'h08, 2'b10, 64'hFFFF);
        rd(1, 8'h04, 2'b10, a); chk("R10 access word A", a, 64'hA5A5_5A5A);
        rd(1, 8'h10, 2'b10, a); chk("R10 access word B", a, 64'h3F);
        rd(1, 8'h08, 2'b10, a); chk("R10 identifier", a, {32'd0, EXP_ID});

        // R1 illegal sizes
        xfer(0, 0, 8'h00, 2'b00, 64'd0);
        chk("R1 error flag", {63'd0, last_err}, 64'd1);
        chk("R1 error data", last_rd, 64'd0);
        xfer(1, 1, 8'h04, 2'b01, 64'hFFFF);
        chk("R1 error on write", {63'd0, last_err}, 64'd1);
        rd(1, 8'h04, 2'b10, a); chk("R1 write dropped", a, 64'hA5A5_5A5A);

        // R11 sweep of unmapped offsets
        for (int cf = 0; cf < 2; cf++) begin
            for (int ad = 0; ad < 72; ad++) begin
                for (int w = 0; w < 2; w++) begin
                    if (!mapped(cf, ad, w)) begin
                        xfer(1, cf[0], 8'(ad), w ? 2'b11 : 2'b10, '1);
                        xfer(0, cf[0], 8'(ad), w ? 2'b11 : 2'b10, 64'd0);
                        chk("R11 read as zero", {last_rd[62:0], last_err}, 64'd0);
                    end
                end
            end
        end
        rd(1, 8'h04, 2'b10, a); chk("R11 access word A kept", a, 64'hA5A5_5A5A);
        rd(1, 8'h10, 2'b10, a); chk("R11 access word B kept", a, 64'h3F);
        rd(1, 8'h18, 2'b11, a); chk("R11 offset kept", a, 64'h1_0000_0000);
        rd(0, 8'h30, 2'b11, a); chk("R11 compare kept", a, 64'h8000_0000_0000_0000);
        rd(0, 8'h3C, 2'b10, a); chk("R11 control kept", a, 64'h5);
        rd(1, 8'h00, 2'b10, a); chk("R11 freq kept", a, 64'd1000);

        done = 1;
        summary();
        $finish;
    end
endmodule